// File: doc/BRIEF.md
# Multi-CPU Interrupt Routing Controller

This block gathers a set of level-sensitive interrupt inputs and steers each of them to one or more processors. Every input has a single global enable bit, a routing word that names the processors allowed to receive it, and, inside each processor's view, a private mask bit. An input counts as eligible for a processor when its level is high and all of these gates are open. Each processor has its own interrupt line, which stays high while it has at least one eligible input.

Software does not edit bitmaps. To enable, disable, mask or unmask an input it writes the input's number to a dedicated command register. The mask commands act on the mask of the processor that issues the access. To service an interrupt, a processor reads its acknowledge register. This returns the lowest-numbered eligible input, or a reserved spurious code when none is eligible. One input number, the per-processor timer, ignores the global enable and the routing word, and is gated only by each processor's own mask.

The register bus is one simple shared port. An access is qualified by `bus_valid` and tagged with the issuing processor. A write takes effect at the clock edge that accepts it. Read data is registered and appears in the cycle after the read.

Top module: `irq_router`

## Requirements
- R1: After reset all global enables are off, every input is masked for every processor, every routing word is zero, every `irq_cpu` bit is low and an acknowledge read returns 0x3FF.
- R2: Writing an input number to offset 0x30 sets that input's global enable, and writing it to offset 0x34 clears it. A number of NUM_SRC or more (bits [9:0] of the data) changes no enable.
- R3: Writing an input number to offset 0x48 masks that input for the processor named on `bus_cpu`, and writing it to offset 0x4C unmasks it. No other processor's mask changes.
- R4: The routing word of input s sits at offset 0x100 + 4*s. Bit c of it lets processor c receive the input. It reads back with every bit at or above NUM_CPU as zero.
- R5: A read of offset 0x00 returns NUM_SRC in bits [11:2], with all other bits zero.
- R6: A read of offset 0x44 returns, in bits [9:0], the lowest-numbered input eligible for the processor named on `bus_cpu`, or 0x3FF when it has none. Bits [31:10] read zero.
- R7: An ordinary input is eligible for processor c only when its level is high, its global enable is set, bit c of its routing word is set and it is unmasked for c.
- R8: Input TIMER_SRC (default 5) is eligible for processor c whenever its level is high and it is unmasked for c, whatever its global enable and routing word hold.
- R9: Inputs are levels. An input stays pending while high and stops being pending in the same cycle it goes low. An acknowledge read changes no state.
- R10: `irq_cpu[c]` is high, combinationally from the current inputs and register state, exactly while processor c has an eligible input.
- R11: An input routed to several processors is presented to all of them at once, and each one's acknowledge read returns it.
- R12: Reads of unassigned offsets return zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_src | input | NUM_SRC | Level of each interrupt input, synchronous to clk |
| bus_valid | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_cpu | input | CPU_W | Number of the processor issuing the access |
| bus_rdata | output | DATA_W | Read data, valid in the cycle after a read |
| irq_cpu | output | NUM_CPU | Interrupt line of each processor |

## Verification
The assertions check every cycle that the enable and mask commands land on the bit that was named. They check that a raised processor line always points at an input that is high and unmasked, that the timer input raises the line as soon as it is high and unmasked, and that the control word and an idle acknowledge read return their fixed values. Only the directed scenarios can show the ordering between several pending inputs and the isolation of one processor's mask from another's. They also show the rejection of out-of-range input numbers that alias onto real ones, the bypass of enable and routing by the timer input, routing to several processors at once, and the silence of unassigned offsets.

// File: rtl/irq_router_pkg.sv
// Package irq_router_pkg
// Shared register offsets and code widths for the interrupt router.
// Assumes byte addressing with 32-bit words.
package irq_router_pkg;
    localparam int ID_W                    = 10;
    localparam logic [ID_W-1:0] SPURIOUS_ID = '1;
    localparam int OFS_CTRL    = 'h000;
    localparam int OFS_EN_SET  = 'h030;
    localparam int OFS_EN_CLR  = 'h034;
    localparam int OFS_ACK     = 'h044;
    localparam int OFS_MSK_SET = 'h048;
    localparam int OFS_MSK_CLR = 'h04C;
    localparam int OFS_ROUTE   = 'h100;
endpackage

// File: rtl/irq_src_regs.sv
// Module irq_src_regs
// Holds the global enable bit and the processor routing word of each input.
// Assumes at most one of the enable commands and the route write per cycle.
module irq_src_regs
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_CPU = 2,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             en_set_we,
    input  logic                             en_clr_we,
    input  logic [ID_W-1:0]                  en_idx,
    input  logic                             route_we,
    input  logic [IDX_W-1:0]                 route_idx,
    input  logic [NUM_CPU-1:0]               route_wdata,
    output logic [NUM_SRC-1:0]               en_q,
    output logic [NUM_SRC-1:0][NUM_CPU-1:0]  route_q
);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        // Per-input enable: set and clear commands compare the full number.
        always_ff @(posedge clk) begin
            if (!rst_n)
                en_q[s] <= 1'b0;
            else if (en_set_we && en_idx == ID_W'(s))
                en_q[s] <= 1'b1;
            else if (en_clr_we && en_idx == ID_W'(s))
                en_q[s] <= 1'b0;
        end

        // Per-input routing word, written whole.
        always_ff @(posedge clk) begin
            if (!rst_n)
                route_q[s] <= '0;
            else if (route_we && route_idx == IDX_W'(s))
                route_q[s] <= route_wdata;
        end
    end

    AST_EN_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_set_we && int'(en_idx) < NUM_SRC) |=> en_q[$past(en_idx[IDX_W-1:0])]); // R2
    AST_EN_CLR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_clr_we && int'(en_idx) < NUM_SRC) |=> !en_q[$past(en_idx[IDX_W-1:0])]); // R2
    AST_EN_RANGE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_set_we || en_clr_we) && int'(en_idx) >= NUM_SRC) |=> $stable(en_q)); // R2

endmodule

// File: rtl/irq_cpu_port.sv
// Module irq_cpu_port
// One processor's view: private mask bits, eligibility of every input and a
// lowest-number-first selector that feeds the acknowledge code and the line.
// Assumes the level inputs are synchronous to clk.
module irq_cpu_port
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC   = 32,
    parameter int TIMER_SRC = 5,
    localparam int IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mask_set_we,
    input  logic                mask_clr_we,
    input  logic [ID_W-1:0]     mask_idx,
    input  logic [NUM_SRC-1:0]  src_level,
    input  logic [NUM_SRC-1:0]  src_en,
    input  logic [NUM_SRC-1:0]  src_route,
    output logic                irq_o,
    output logic [ID_W-1:0]     ack_id
);

    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] elig;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        // Private mask bit: reset masked, set/clear by input number.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_q[s] <= 1'b1;
            else if (mask_set_we && mask_idx == ID_W'(s))
                mask_q[s] <= 1'b1;
            else if (mask_clr_we && mask_idx == ID_W'(s))
                mask_q[s] <= 1'b0;
        end

        if (s == TIMER_SRC) begin : g_timer
            // Timer input: gated by the private mask only.
            always_comb elig[s] = src_level[s] && !mask_q[s];
        end else begin : g_shared
            // Ordinary input: level, enable, route and mask all required.
            always_comb elig[s] = src_level[s] && src_en[s] && src_route[s] && !mask_q[s];
        end
    end

    // Lowest-numbered eligible input wins; none gives the spurious code.
    always_comb begin
        ack_id = SPURIOUS_ID;
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (elig[s])
                ack_id = ID_W'(s);
        end
    end

    // Line is high while any input is eligible.
    always_comb irq_o = |elig;

    AST_MASK_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_set_we && int'(mask_idx) < NUM_SRC) |=> mask_q[$past(mask_idx[IDX_W-1:0])]); // R3
    AST_MASK_CLR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_clr_we && int'(mask_idx) < NUM_SRC) |=> !mask_q[$past(mask_idx[IDX_W-1:0])]); // R3
    AST_LINE_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (src_level[ack_id[IDX_W-1:0]] && !mask_q[ack_id[IDX_W-1:0]])); // R7
    AST_TIMER_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (src_level[TIMER_SRC] && !mask_q[TIMER_SRC]) |-> irq_o); // R8

endmodule

// File: rtl/irq_router.sv
// Module irq_router
// Top of the interrupt router: decodes the register bus, keeps the shared
// per-input state and instantiates one port per processor.
// Assumes one access per cycle; read data is registered.
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC   = 32,
    parameter int NUM_CPU   = 2,
    parameter int TIMER_SRC = 5,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    localparam int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_src,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [CPU_W-1:0]   bus_cpu,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [NUM_CPU-1:0] irq_cpu
);

    localparam int ROUTE_END = OFS_ROUTE + 4 * NUM_SRC;

    logic                            wr, rd;
    logic                            hit_en_set, hit_en_clr, hit_msk_set, hit_msk_clr;
    logic                            hit_ctrl, hit_ack, hit_route;
    logic [ADDR_W-1:0]               rel_addr;
    logic [IDX_W-1:0]                route_idx;
    logic [NUM_SRC-1:0]              en_q;
    logic [NUM_SRC-1:0][NUM_CPU-1:0] route_q;
    logic [NUM_CPU-1:0][ID_W-1:0]    ack_ids;
    logic                            cpu_ok;
    logic                            sel_irq;
    logic [DATA_W-1:0]               rd_val;

    // Address decode of the shared register port.
    always_comb begin
        wr          = bus_valid && bus_write;
        rd          = bus_valid && !bus_write;
        hit_ctrl    = int'(bus_addr) == OFS_CTRL;
        hit_en_set  = int'(bus_addr) == OFS_EN_SET;
        hit_en_clr  = int'(bus_addr) == OFS_EN_CLR;
        hit_ack     = int'(bus_addr) == OFS_ACK;
        hit_msk_set = int'(bus_addr) == OFS_MSK_SET;
        hit_msk_clr = int'(bus_addr) == OFS_MSK_CLR;
        hit_route   = int'(bus_addr) >= OFS_ROUTE && int'(bus_addr) < ROUTE_END
                      && bus_addr[1:0] == 2'b00;
        rel_addr    = bus_addr - ADDR_W'(OFS_ROUTE);
        route_idx   = rel_addr[IDX_W+1:2];
        cpu_ok      = int'(bus_cpu) < NUM_CPU;
        sel_irq     = cpu_ok && irq_cpu[bus_cpu];
    end

    irq_src_regs #(
        .NUM_SRC (NUM_SRC),
        .NUM_CPU (NUM_CPU)
    ) u_src (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_set_we   (wr && hit_en_set),
        .en_clr_we   (wr && hit_en_clr),
        .en_idx      (bus_wdata[ID_W-1:0]),
        .route_we    (wr && hit_route),
        .route_idx   (route_idx),
        .route_wdata (bus_wdata[NUM_CPU-1:0]),
        .en_q        (en_q),
        .route_q     (route_q)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic [NUM_SRC-1:0] route_col;

        // Extract this processor's column of the routing words.
        always_comb begin
            for (int s = 0; s < NUM_SRC; s++)
                route_col[s] = route_q[s][c];
        end

        irq_cpu_port #(
            .NUM_SRC   (NUM_SRC),
            .TIMER_SRC (TIMER_SRC)
        ) u_port (
            .clk         (clk),
            .rst_n       (rst_n),
            .mask_set_we (wr && hit_msk_set && bus_cpu == CPU_W'(c)),
            .mask_clr_we (wr && hit_msk_clr && bus_cpu == CPU_W'(c)),
            .mask_idx    (bus_wdata[ID_W-1:0]),
            .src_level   (irq_src),
            .src_en      (en_q),
            .src_route   (route_col),
            .irq_o       (irq_cpu[c]),
            .ack_id      (ack_ids[c])
        );
    end

    // Read multiplexer over control, acknowledge and routing words.
    always_comb begin
        rd_val = '0;
        if (hit_ctrl)
            rd_val[11:2] = ID_W'(NUM_SRC);
        else if (hit_ack)
            rd_val[ID_W-1:0] = cpu_ok ? ack_ids[bus_cpu] : SPURIOUS_ID;
        else if (hit_route)
            rd_val[NUM_CPU-1:0] = route_q[route_idx];
    end

    // Registered read data, held until the next read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (rd)
            bus_rdata <= rd_val;
    end

    AST_CTRL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && hit_ctrl) |=> (bus_rdata[11:2] == ID_W'(NUM_SRC) && bus_rdata[1:0] == 2'b00)); // R5
    AST_IDLE_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && hit_ack && !sel_irq) |=> (bus_rdata[ID_W-1:0] == SPURIOUS_ID)); // R6
    AST_ACK_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && hit_ack) |=> (bus_rdata[DATA_W-1:ID_W] == '0)); // R6

endmodule

// File: tb/irq_router_tb.sv
// Directed bench for irq_router: one task per scenario, each checking itself.
module irq_router_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 32;
    localparam int NCPU = 2;
    localparam int WATCHDOG = 20000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NSRC-1:0]   irq_src;
    logic              bus_valid, bus_write;
    logic [11:0]       bus_addr;
    logic [31:0]       bus_wdata;
    logic [0:0]        bus_cpu;
    logic [31:0]       bus_rdata;
    logic [NCPU-1:0]   irq_cpu;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_router #(.NUM_SRC(NSRC), .NUM_CPU(NCPU), .TIMER_SRC(5)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_cpu(bus_cpu), .bus_rdata(bus_rdata), .irq_cpu(irq_cpu)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; irq_src = '0; bus_valid = 1'b0; bus_write = 1'b0;
        bus_addr = '0; bus_wdata = '0; bus_cpu = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input int cpu, input int a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 12'(a);
        bus_wdata = d; bus_cpu = 1'(cpu);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input int cpu, input int a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 12'(a); bus_cpu = 1'(cpu);
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_src(input int s, input logic v);
        @(negedge clk);
        irq_src[s] = v;
        #1;
    endtask

    // R1 and R5: state straight after reset.
    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        irq_src = '1;
        #1;
        chk("R1 irq lines", 32'(irq_cpu), 32'h0);
        rd(0, 'h44, d); chk("R1 ack cpu0", d, 32'h3FF);
        rd(1, 'h44, d); chk("R1 ack cpu1", d, 32'h3FF);
        rd(0, 'h100 + 4*3, d); chk("R1 route word", d, 32'h0);
        rd(0, 'h00, d); chk("R5 control word", d, 32'(NSRC) << 2);
    endtask

    // R2, R7, R10: enable and route one input to cpu0.
    task automatic t_enable();
        logic [31:0] d;
        do_reset();
        wr(0, 'h100 + 4*3, 32'h1);
        wr(0, 'h4C, 32'd3);
        set_src(3, 1'b1);
        chk("R7 not enabled", 32'(irq_cpu), 32'h0);
        wr(1, 'h30, 32'd35);
        chk("R2 out-of-range enable", 32'(irq_cpu), 32'h0);
        wr(1, 'h30, 32'd3);
        chk("R10 line cpu0", 32'(irq_cpu), 32'h1);
        rd(0, 'h44, d); chk("R6 ack cpu0", d, 32'd3);
        rd(1, 'h44, d); chk("R7 cpu1 not routed", d, 32'h3FF);
        wr(0, 'h34, 32'd35);
        chk("R2 out-of-range clear", 32'(irq_cpu), 32'h1);
        wr(0, 'h34, 32'd3);
        chk("R2 disable", 32'(irq_cpu), 32'h0);
    endtask

    // R3 and R11: per-cpu masks and multi-cpu routing.
    task automatic t_masks();
        logic [31:0] d;
        do_reset();
        wr(0, 'h100 + 4*9, 32'h3);
        wr(0, 'h30, 32'd9);
        set_src(9, 1'b1);
        wr(0, 'h4C, 32'd9);
        chk("R3 unmask own cpu only", 32'(irq_cpu), 32'h1);
        wr(1, 'h4C, 32'd9);
        chk("R11 both lines", 32'(irq_cpu), 32'h3);
        rd(0, 'h44, d); chk("R11 ack cpu0", d, 32'd9);
        rd(1, 'h44, d); chk("R11 ack cpu1", d, 32'd9);
        wr(1, 'h48, 32'd9);
        chk("R3 mask cpu1 only", 32'(irq_cpu), 32'h1);
    endtask

    // R6 and R9: ordering and level behaviour.
    task automatic t_priority();
        logic [31:0] d;
        do_reset();
        wr(0, 'h100 + 4*3, 32'h1);
        wr(0, 'h100 + 4*7, 32'h1);
        wr(0, 'h30, 32'd3); wr(0, 'h30, 32'd7);
        wr(0, 'h4C, 32'd3); wr(0, 'h4C, 32'd7);
        set_src(7, 1'b1); set_src(3, 1'b1);
        rd(0, 'h44, d); chk("R6 lowest first", d, 32'd3);
        rd(0, 'h44, d); chk("R9 ack no side effect", d, 32'd3);
        set_src(3, 1'b0);
        rd(0, 'h44, d); chk("R9 level drop", d, 32'd7);
        set_src(7, 1'b0);
        chk("R9 line drops", 32'(irq_cpu), 32'h0);
        rd(0, 'h44, d); chk("R6 spurious", d, 32'h3FF);
    endtask

    // R8: timer input ignores enable and route.
    task automatic t_timer();
        logic [31:0] d;
        do_reset();
        set_src(5, 1'b1);
        chk("R8 masked timer", 32'(irq_cpu), 32'h0);
        wr(1, 'h4C, 32'd5);
        chk("R8 timer cpu1 only", 32'(irq_cpu), 32'h2);
        rd(1, 'h44, d); chk("R8 timer ack", d, 32'd5);
    endtask

    // R4 and R12: routing word readback and unassigned offsets.
    task automatic t_regs();
        logic [31:0] d;
        do_reset();
        wr(0, 'h100 + 4*10, 32'hFFFF_FFFF);
        rd(0, 'h100 + 4*10, d); chk("R4 route readback", d, 32'h3);
        rd(0, 'h100 + 4*11, d); chk("R4 neighbour untouched", d, 32'h0);
        wr(0, 'h20, 32'd10);
        wr(0, 'h4C, 32'd10);
        set_src(10, 1'b1);
        chk("R12 write ignored", 32'(irq_cpu), 32'h0);
        rd(0, 'h20, d); chk("R12 read zero", d, 32'h0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=%0d exp=done", WATCHDOG);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_enable();
        t_masks();
        t_priority();
        t_timer();
        t_regs();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule